// File: doc/BRIEF.md
# Coprocessor Accumulator Transfer Unit

This block holds a single 40-bit accumulator and carries out two-register transfers between it and a 32-bit core register file. Each cycle it can take one instruction word with a valid strobe. The word comes with a condition-passed bit from the core's condition logic, two 32-bit source operands and a coprocessor access-enable bit. A matching transfer either loads the accumulator from the operand pair or returns the accumulator as a high/low register pair. The read result carries the two destination register indices for writeback.

The high word of the pair covers only accumulator bits 39:32. On a load, the upper 24 bits of the high operand are dropped. On a read, bit 39 is sign-extended through the high result. A word that is recognised but not permitted raises a one-cycle undefined-instruction pulse and changes nothing. A separate load port lets the external multiply-accumulate datapath write all 40 bits. A transfer load beats that port when both write in the same cycle. The current accumulator value is driven out for that datapath.

Top module: `acc_xfer_unit`

## Requirements
- R1: Synchronous active-high reset clears the accumulator to zero and holds the writeback-valid and undefined outputs low.
- R2: A word is a transfer only if bits 27:21 equal 1100010 and bits 11:8 equal 0000. Any other word causes no accumulator change, no writeback and no undefined pulse.
- R3: A permitted transfer with bit 20 = 0 sets the accumulator, at the next edge, to the low 8 bits of the high operand in bits 39:32 and the low operand in bits 31:0. High operand bits 31:8 are discarded.
- R4: A permitted transfer with bit 20 = 1 raises writeback-valid for one cycle after the edge. The low result is accumulator bits 31:0 and the high result is bits 39:32 sign-extended to 32 bits. The high index is bits 19:16 and the low index is bits 15:12.
- R5: A recognised transfer with access-enable low gives a one-cycle undefined pulse and no transfer or writeback.
- R6: A recognised transfer with any of bits 7:3 set gives an undefined pulse and no transfer or writeback.
- R7: A recognised transfer with a nonzero accumulator select in bits 2:0 gives an undefined pulse and no transfer or writeback.
- R8: A valid word presented with condition-passed low has no effect and raises no undefined pulse.
- R9: The external load port writes all 40 bits at the next edge.
- R10: When a transfer load and an external load happen in the same cycle, the transfer load wins.
- R11: A read returns the accumulator value from before any external load in the same cycle. Writeback-valid and undefined are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition check passed for this word |
| cp_access_en | input | 1 | Coprocessor access permission |
| src_hi | input | 32 | High-order source operand |
| src_lo | input | 32 | Low-order source operand |
| ext_load_en | input | 1 | External load strobe |
| ext_load_data | input | 40 | External load value |
| acc_out | output | 40 | Current accumulator value |
| wb_valid | output | 1 | Read result valid |
| wb_hi_idx | output | 4 | Destination index of high result |
| wb_lo_idx | output | 4 | Destination index of low result |
| wb_hi_data | output | 32 | Sign-extended high result |
| wb_lo_data | output | 32 | Low result |
| undef_pulse | output | 1 | Undefined-instruction pulse |

## Verification
Loads use high operands whose bit 7 is clear, bit 7 set, and garbage in bits 31:8. This separates correct truncation and sign extension from zero extension or a pass-through of the full word. Words that are nearly transfers (wrong opcode, wrong coprocessor number), and transfers with access denied, must-be-zero bits set, a nonzero accumulator select or a failed condition, check that rejection and flagging are told apart. Same-cycle combinations of transfer load, external load and read check the write priority and the read-before-write ordering. A long random mix is compared every cycle against the behavioural model.

// File: rtl/acc_xfer_pkg.sv
package acc_xfer_pkg;

  localparam logic [6:0] XFER_OPCODE = 7'b1100010;
  localparam logic [3:0] XFER_CPNUM  = 4'b0000;
  localparam int         RIDX_W      = 4;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic              bad;
    logic [RIDX_W-1:0] hi_idx;
    logic [RIDX_W-1:0] lo_idx;
  } xfer_dec_t;

endpackage

// File: rtl/acc_xfer_decode.sv
module acc_xfer_decode
  import acc_xfer_pkg::*;
#(
  parameter int INSTR_W   = 32,
  parameter int ACC_COUNT = 1
) (
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic               cond_pass,
  input  logic               cp_access_en,
  output xfer_dec_t          dec
);

  logic       is_xfer;
  logic       hit;
  logic       mbz_bad;
  logic       sel_bad;
  logic [2:0] acc_sel;
  logic       unused_cond;

  assign unused_cond = ^instr_word[31:28];
  assign acc_sel     = instr_word[2:0];
  assign is_xfer     = (instr_word[27:21] == XFER_OPCODE) &&
                       (instr_word[11:8]  == XFER_CPNUM);
  assign hit         = instr_valid && cond_pass && is_xfer;
  assign mbz_bad     = (instr_word[7:3] != 5'd0);
  assign sel_bad     = (int'(acc_sel) >= ACC_COUNT);

  always_comb begin
    dec        = '0;
    dec.bad    = hit && (!cp_access_en || mbz_bad || sel_bad);
    dec.wr     = hit && !dec.bad && !instr_word[20];
    dec.rd     = hit && !dec.bad &&  instr_word[20];
    dec.hi_idx = instr_word[19:16];
    dec.lo_idx = instr_word[15:12];
  end

  AST_EXCL_DEC: assert final (!(dec.wr && dec.rd) && !(dec.bad && (dec.wr || dec.rd))); // R11

endmodule

// File: rtl/acc_xfer_store.sv
module acc_xfer_store #(
  parameter int ACC_W = 40,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_wr,
  input  logic [REG_W-1:0] src_hi,
  input  logic [REG_W-1:0] src_lo,
  input  logic             ext_wr,
  input  logic [ACC_W-1:0] ext_data,
  output logic [ACC_W-1:0] acc_q
);

  localparam int HI_W = ACC_W - REG_W;

  logic [ACC_W-1:0] xfer_val;
  logic             unused_hi;
  logic             rst_d;

  assign unused_hi = ^src_hi[REG_W-1:HI_W];
  assign xfer_val  = {src_hi[HI_W-1:0], src_lo};

  always_ff @(posedge clk) begin
    if (rst)          acc_q <= '0;
    else if (xfer_wr) acc_q <= xfer_val;
    else if (ext_wr)  acc_q <= ext_data;
  end

  always_ff @(posedge clk) rst_d <= rst;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> acc_q == '0); // R1
  AST_EXT_LOAD: assert property (@(posedge clk) disable iff (rst)
    $past(ext_wr && !xfer_wr) |-> acc_q == $past(ext_data)); // R9
  AST_XFER_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(xfer_wr) |-> acc_q[REG_W-1:0] == $past(src_lo)); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(!xfer_wr && !ext_wr) |-> $stable(acc_q)); // R5

endmodule

// File: rtl/acc_xfer_readout.sv
module acc_xfer_readout
  import acc_xfer_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int REG_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  xfer_dec_t         dec,
  input  logic [ACC_W-1:0]  acc_q,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_hi_idx,
  output logic [RIDX_W-1:0] wb_lo_idx,
  output logic [REG_W-1:0]  wb_hi_data,
  output logic [REG_W-1:0]  wb_lo_data,
  output logic              undef_pulse
);

  localparam int HI_W  = ACC_W - REG_W;
  localparam int EXT_W = REG_W - HI_W;

  logic [REG_W-1:0] hi_ext;
  assign hi_ext = {{EXT_W{acc_q[ACC_W-1]}}, acc_q[ACC_W-1:REG_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid    <= 1'b0;
      undef_pulse <= 1'b0;
    end else begin
      wb_valid    <= dec.rd;
      undef_pulse <= dec.bad;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_hi_idx  <= '0;
      wb_lo_idx  <= '0;
      wb_hi_data <= '0;
      wb_lo_data <= '0;
    end else if (dec.rd) begin
      wb_hi_idx  <= dec.hi_idx;
      wb_lo_idx  <= dec.lo_idx;
      wb_hi_data <= hi_ext;
      wb_lo_data <= acc_q[REG_W-1:0];
    end
  end

  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> wb_hi_data[REG_W-1:HI_W] == {EXT_W{wb_hi_data[HI_W-1]}}); // R4
  AST_READ_OLD: assert property (@(posedge clk) disable iff (rst)
    $past(dec.rd) |-> wb_lo_data == $past(acc_q[REG_W-1:0])); // R11
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(wb_valid && undef_pulse)); // R11

endmodule

// File: rtl/acc_xfer_unit.sv
module acc_xfer_unit
  import acc_xfer_pkg::*;
#(
  parameter int ACC_W     = 40,
  parameter int REG_W     = 32,
  parameter int ACC_COUNT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  input  logic              cond_pass,
  input  logic              cp_access_en,
  input  logic [REG_W-1:0]  src_hi,
  input  logic [REG_W-1:0]  src_lo,
  input  logic              ext_load_en,
  input  logic [ACC_W-1:0]  ext_load_data,
  output logic [ACC_W-1:0]  acc_out,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_hi_idx,
  output logic [RIDX_W-1:0] wb_lo_idx,
  output logic [REG_W-1:0]  wb_hi_data,
  output logic [REG_W-1:0]  wb_lo_data,
  output logic              undef_pulse
);

  localparam int HI_W = ACC_W - REG_W;

  xfer_dec_t        dec;
  logic [ACC_W-1:0] acc_q;

  acc_xfer_decode #(.INSTR_W(32), .ACC_COUNT(ACC_COUNT)) u_decode (
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .cond_pass   (cond_pass),
    .cp_access_en(cp_access_en),
    .dec         (dec)
  );

  acc_xfer_store #(.ACC_W(ACC_W), .REG_W(REG_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .xfer_wr (dec.wr),
    .src_hi  (src_hi),
    .src_lo  (src_lo),
    .ext_wr  (ext_load_en),
    .ext_data(ext_load_data),
    .acc_q   (acc_q)
  );

  acc_xfer_readout #(.ACC_W(ACC_W), .REG_W(REG_W)) u_readout (
    .clk        (clk),
    .rst        (rst),
    .dec        (dec),
    .acc_q      (acc_q),
    .wb_valid   (wb_valid),
    .wb_hi_idx  (wb_hi_idx),
    .wb_lo_idx  (wb_lo_idx),
    .wb_hi_data (wb_hi_data),
    .wb_lo_data (wb_lo_data),
    .undef_pulse(undef_pulse)
  );

  assign acc_out = acc_q;

  AST_COND_FAIL: assert property (@(posedge clk) disable iff (rst)
    $past(instr_valid && !cond_pass) |-> !undef_pulse && !wb_valid); // R8
  AST_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    $past(instr_valid && cond_pass && !cp_access_en &&
          instr_word[27:21] == XFER_OPCODE && instr_word[11:8] == XFER_CPNUM)
    |-> undef_pulse && !wb_valid); // R5
  AST_TRUNC_HI: assert property (@(posedge clk) disable iff (rst)
    $past(dec.wr) |-> acc_out[ACC_W-1:REG_W] == $past(src_hi[HI_W-1:0])); // R3
  AST_FOREIGN: assert property (@(posedge clk) disable iff (rst)
    $past(instr_word[27:21] != XFER_OPCODE || !instr_valid) |-> !undef_pulse && !wb_valid); // R2

endmodule

// File: tb/acc_xfer_unit_bench.sv
module acc_xfer_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        cond_pass = 1'b0;
  logic        cp_access_en = 1'b0;
  logic [31:0] src_hi = '0, src_lo = '0;
  logic        ext_load_en = 1'b0;
  logic [39:0] ext_load_data = '0;
  logic [39:0] acc_out;
  logic        wb_valid, undef_pulse;
  logic [3:0]  wb_hi_idx, wb_lo_idx;
  logic [31:0] wb_hi_data, wb_lo_data;

  int checks = 0;
  int errors = 0;

  logic [39:0] m_acc = '0;
  logic        e_wbv, e_und;
  logic [3:0]  e_hidx, e_lidx;
  logic [31:0] e_hi, e_lo;

  always #2 clk = ~clk;

  acc_xfer_unit u_acc_xfer_unit (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .cond_pass(cond_pass), .cp_access_en(cp_access_en), .src_hi(src_hi),
    .src_lo(src_lo), .ext_load_en(ext_load_en), .ext_load_data(ext_load_data),
    .acc_out(acc_out), .wb_valid(wb_valid), .wb_hi_idx(wb_hi_idx),
    .wb_lo_idx(wb_lo_idx), .wb_hi_data(wb_hi_data), .wb_lo_data(wb_lo_data),
    .undef_pulse(undef_pulse)
  );

  function automatic logic [31:0] mk(input logic rd, input logic [3:0] hi,
                                     input logic [3:0] lo, input logic [4:0] mbz,
                                     input logic [2:0] sel);
    return {4'hE, 7'b1100010, rd, hi, lo, 4'b0000, mbz, sel};
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req);
    logic hit, bad, wrote;
    e_wbv = 1'b0; e_und = 1'b0; wrote = 1'b0;
    hit = instr_valid && cond_pass && instr_word[27:21] == 7'b1100010 &&
          instr_word[11:8] == 4'd0;
    bad = !cp_access_en || instr_word[7:3] != 0 || instr_word[2:0] != 0;
    if (hit && bad) e_und = 1'b1;
    else if (hit && instr_word[20]) begin
      e_wbv  = 1'b1;
      e_hidx = instr_word[19:16];
      e_lidx = instr_word[15:12];
      e_hi   = 32'(signed'(m_acc[39:32]));
      e_lo   = m_acc[31:0];
    end else if (hit) begin
      m_acc = {src_hi[7:0], src_lo};
      wrote = 1'b1;
    end
    if (!wrote && ext_load_en) m_acc = ext_load_data;
    @(posedge clk);
    @(negedge clk);
    check(acc_out == m_acc, req, "acc", 64'(acc_out), 64'(m_acc));
    check(wb_valid == e_wbv, req, "wb_valid", 64'(wb_valid), 64'(e_wbv));
    check(undef_pulse == e_und, req, "undef", 64'(undef_pulse), 64'(e_und));
    if (e_wbv) begin
      check({wb_hi_data, wb_lo_data} == {e_hi, e_lo}, req, "wb data",
            {wb_hi_data, wb_lo_data}, {e_hi, e_lo});
      check({wb_hi_idx, wb_lo_idx} == {e_hidx, e_lidx}, req, "wb idx",
            64'({wb_hi_idx, wb_lo_idx}), 64'({e_hidx, e_lidx}));
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] w, input logic c,
                       input logic en, input logic [31:0] h, input logic [31:0] l,
                       input logic xe, input logic [39:0] xd, input string req);
    instr_valid = v; instr_word = w; cond_pass = c; cp_access_en = en;
    src_hi = h; src_lo = l; ext_load_en = xe; ext_load_data = xd;
    step(req);
    instr_valid = 1'b0; ext_load_en = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(acc_out == 0 && !wb_valid && !undef_pulse, "R1", "reset state",
          64'(acc_out), 64'd0);
    // R3: garbage in upper high operand bits, bit 7 clear
    drive(1, mk(0, 4'd2, 4'd3, 0, 0), 1, 1, 32'hFFFFFF7F, 32'h9ABCDEF0, 0, 0, "R3");
    // R4: positive sign
    drive(1, mk(1, 4'd5, 4'd6, 0, 0), 1, 1, 0, 0, 0, 0, "R4");
    drive(1, mk(0, 4'd1, 4'd0, 0, 0), 1, 1, 32'h00000080, 32'h00000001, 0, 0, "R3");
    drive(1, mk(1, 4'd14, 4'd9, 0, 0), 1, 1, 0, 0, 0, 0, "R4");
    // R5: access disabled
    drive(1, mk(0, 4'd1, 4'd2, 0, 0), 1, 0, 32'h11, 32'h22, 0, 0, "R5");
    drive(1, mk(1, 4'd1, 4'd2, 0, 0), 1, 0, 0, 0, 0, 0, "R5");
    // R6: must-be-zero bits
    drive(1, mk(0, 4'd1, 4'd2, 5'b10000, 0), 1, 1, 32'h33, 32'h44, 0, 0, "R6");
    drive(1, mk(1, 4'd1, 4'd2, 5'b00001, 0), 1, 1, 0, 0, 0, 0, "R6");
    // R7: nonzero accumulator select
    drive(1, mk(0, 4'd1, 4'd2, 0, 3'd3), 1, 1, 32'h55, 32'h66, 0, 0, "R7");
    drive(1, mk(1, 4'd1, 4'd2, 0, 3'd7), 1, 1, 0, 0, 0, 0, "R7");
    // R8: condition failed, including a would-be-undefined word
    drive(1, mk(0, 4'd1, 4'd2, 0, 0), 0, 1, 32'h77, 32'h88, 0, 0, "R8");
    drive(1, mk(0, 4'd1, 4'd2, 5'b11111, 0), 0, 0, 0, 0, 0, 0, "R8");
    // R2: near misses
    drive(1, mk(0, 4'd1, 4'd2, 0, 0) | 32'h00000100, 1, 1, 32'h99, 32'hAA, 0, 0, "R2");
    drive(1, mk(0, 4'd1, 4'd2, 0, 0) ^ 32'h00400000, 1, 0, 32'h99, 32'hAA, 0, 0, "R2");
    // R9: external load, then read back negative value
    drive(0, 0, 0, 1, 0, 0, 1, 40'hC3_DEADBEEF, "R9");
    drive(1, mk(1, 4'd7, 4'd8, 0, 0), 1, 1, 0, 0, 0, 0, "R9");
    // R10: both writes in one cycle
    drive(1, mk(0, 4'd0, 4'd1, 0, 0), 1, 1, 32'hABCDEF12, 32'h01020304, 1, 40'hFF_FFFFFFFF, "R10");
    // R10: rejected transfer lets external load through
    drive(1, mk(0, 4'd0, 4'd1, 0, 3'd1), 1, 1, 32'h1, 32'h2, 1, 40'h5A_A5A5A5A5, "R10");
    // R11: read with same-cycle external load returns old value
    drive(1, mk(1, 4'd3, 4'd4, 0, 0), 1, 1, 0, 0, 1, 40'h01_00000000, "R11");
    drive(1, mk(1, 4'd3, 4'd4, 0, 0), 1, 1, 0, 0, 0, 0, "R11");
    // random mix, compared each cycle
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      w = mk($urandom_range(0, 1), 4'($urandom), 4'($urandom),
             ($urandom_range(0, 5) == 0) ? 5'($urandom) : 5'd0,
             ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'd0);
      if ($urandom_range(0, 7) == 0) w = $urandom;
      drive($urandom_range(0, 3) != 0, w, $urandom_range(0, 5) != 0,
            $urandom_range(0, 7) != 0, $urandom, $urandom,
            $urandom_range(0, 3) == 0, {8'($urandom), 32'($urandom)}, "R11");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule